// File: doc/BRIEF.md
# Register-Mapped Byte-Serial SPI Host

This block is a host-side serial peripheral interface controller that sits on a simple 32-bit register bus. Software configures a clock divider and a clock mode. It drives the chip select through a register bit. It starts each byte exchange by writing the transmit register. The block then clocks eight bits out on MOSI while it captures eight bits from MISO, most significant bit first. When the exchange is done, it raises a receive-full flag.

The serial clock comes from the system clock through two stages. The first stage is a prescaler, either the low or the high ratio (16 or 128 by default). The second stage is a programmable count of N+1 prescaled periods for each half of the serial clock period. The serial clock therefore runs at f_clk / (P × 2 × (N+1)). Changes to the clock setup take effect at the start of the next byte. A running exchange is never disturbed, either by a new transmit write or by a configuration write.

Register offsets:
- 0x00: setup register. Bit 7 is the phase, bit 6 the polarity, bit 5 the prescaler select and bits 4:0 the value N.
- 0x04: flags. Bit 0 is busy and bit 2 is receive-full.
- 0x08: line control. Bit 6 is the select level.
- 0x0C: transmit byte.
- 0x10: received byte.

Reads of any other offset return zero.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the chip select output is high, SCK is low, the flags register reads 0, the setup register reads 0 and the line control register reads 0x40.
- R2: One cycle after a write to the line control register (0x08), spi_cs_n equals bit 6 of the written value (0 selects the device, 1 releases it).
- R3: A byte exchange produces exactly 16 SCK transitions, spaced P×(N+1) system clocks apart. P is 16 when setup bit 5 is 0 and 128 when it is 1, and N is setup bits 4:0.
- R4: While no exchange runs, SCK rests at the level of setup bit 6 (polarity), and it toggles only during an exchange.
- R5: The transmitted byte leaves on MOSI most significant bit first. With setup bit 7 (phase) at 0, each bit is valid before the leading SCK edge and is sampled there. With phase 1, each bit is driven on the leading edge and sampled on the trailing edge.
- R6: The byte sampled from MISO under the same phase rule reads back from the received byte register (0x10, bits 7:0) once the exchange ends.
- R7: Flags bit 0 reads 1 from the cycle after a transmit write that starts an exchange until the exchange ends, and reads 0 afterwards.
- R8: Flags bit 2 becomes 1 when an exchange ends. It is cleared by a read of the received byte register, or by a write of a value with bit 2 at 0 to the flags register (0x04). The received byte stays readable after such a write.
- R9: A transmit write while an exchange runs is ignored. The running exchange keeps its byte and its timing, and the transmit register (0x0C) still reads back the original byte.
- R10: A setup write during an exchange does not change that exchange's SCK timing. It reads back at once and governs the next exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects on 0x10) |
| bus_addr | input | AW (5) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs all four clock modes against a slave model that shifts in step with each mode. A design that swaps leading and trailing edges returns a byte shifted by one bit, or loses its top bit. It measures the spacing of every SCK transition, at both prescaler settings and at the largest N, so an off-by-one in the reload value or a prescaler picked the wrong way shows up as a wrong interval. It writes the transmit register and the setup register in the middle of an exchange. A design that restarts the exchange or retimes it at once produces extra edges, a corrupted byte or a changed interval. It also clears the receive flag through the flags register instead of a read, which catches a design that ignores that path or loses the data.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int DIV_W = 5;

    localparam logic [7:0] OFS_SETUP = 8'h00;
    localparam logic [7:0] OFS_FLAGS = 8'h04;
    localparam logic [7:0] OFS_LINE  = 8'h08;
    localparam logic [7:0] OFS_TX    = 8'h0C;
    localparam logic [7:0] OFS_RX    = 8'h10;

    localparam int FLAG_BUSY  = 0;
    localparam int FLAG_FULL  = 2;
    localparam int LINE_SEL   = 6;

    localparam logic [7:0] LINE_RESET = 8'h40;

    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             pre_hi;
        logic [DIV_W-1:0] div;
    } setup_t;

    typedef struct packed {
        logic cpha;
        logic cpol;
    } mode_t;

    function automatic mode_t mode_of(setup_t s);
        mode_t m;
        m.cpha = s.cpha;
        m.cpol = s.cpol;
        return m;
    endfunction

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int AW     = 5,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rx,
    output setup_t            setup_q,
    output logic              cs_n,
    output logic              start,
    output logic [WORD_W-1:0] tx_q
);

    logic [7:0]        line_q;
    logic [WORD_W-1:0] rx_q;
    logic              rx_full;
    logic              hit_setup, hit_flags, hit_line, hit_tx, hit_rx;
    logic              unused_wdata;

    assign hit_setup = (addr == AW'(OFS_SETUP));
    assign hit_flags = (addr == AW'(OFS_FLAGS));
    assign hit_line  = (addr == AW'(OFS_LINE));
    assign hit_tx    = (addr == AW'(OFS_TX));
    assign hit_rx    = (addr == AW'(OFS_RX));

    assign start = wr_en && hit_tx && !eng_busy;
    assign cs_n  = line_q[LINE_SEL];
    assign unused_wdata = ^wdata[31:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
            line_q  <= LINE_RESET;
            tx_q    <= '0;
        end else if (wr_en) begin
            if (hit_setup) setup_q <= setup_t'(wdata[7:0]);
            if (hit_line)  line_q  <= wdata[7:0];
            if (start)     tx_q    <= wdata[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            rx_full <= 1'b0;
        end else if (eng_done) begin
            rx_q    <= eng_rx;
            rx_full <= 1'b1;
        end else if (rd_en && hit_rx) begin
            rx_full <= 1'b0;
        end else if (wr_en && hit_flags && !wdata[FLAG_FULL]) begin
            rx_full <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_setup) begin
            rdata[7:0] = setup_q;
        end else if (hit_flags) begin
            rdata[FLAG_BUSY] = eng_busy;
            rdata[FLAG_FULL] = rx_full;
        end else if (hit_line) begin
            rdata[7:0] = line_q;
        end else if (hit_tx) begin
            rdata[WORD_W-1:0] = tx_q;
        end else if (hit_rx) begin
            rdata[WORD_W-1:0] = rx_q;
        end
    end

endmodule

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] half_per,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_q;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            reload_q <= '0;
        end else if (start) begin
            reload_q <= half_per;
            cnt      <= half_per - CNT_W'(1);
        end else if (run) begin
            cnt <= (cnt == '0) ? reload_q - CNT_W'(1) : cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  mode_t             mode_in,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_byte,
    output logic              sck_q,
    output logic              mosi
);

    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES);

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    eng_state_t        state;
    mode_t             mode_q;
    logic [EW-1:0]     edge_cnt;
    logic [WORD_W-1:0] sh;
    logic              samp;
    logic              leading, last;

    assign busy    = (state == ENG_SHIFT);
    assign leading = ~edge_cnt[0];
    assign last    = (edge_cnt == EW'(EDGES - 1));
    assign rx_byte = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            mode_q   <= '0;
            edge_cnt <= '0;
            sh       <= '0;
            samp     <= 1'b0;
            sck_q    <= 1'b0;
            mosi     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state    <= ENG_SHIFT;
                mode_q   <= mode_in;
                edge_cnt <= '0;
                sh       <= tx_byte;
                sck_q    <= mode_in.cpol;
                if (!mode_in.cpha) mosi <= tx_byte[WORD_W-1];
            end else if (busy && tick) begin
                sck_q    <= ~sck_q;
                edge_cnt <= edge_cnt + EW'(1);
                if (leading) begin
                    if (!mode_q.cpha) samp <= miso;
                    else              mosi <= sh[WORD_W-1];
                end else begin
                    if (!mode_q.cpha) begin
                        sh <= {sh[WORD_W-2:0], samp};
                        if (!last) mosi <= sh[WORD_W-2];
                    end else begin
                        sh <= {sh[WORD_W-2:0], miso};
                    end
                end
                if (last) begin
                    state <= ENG_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int AW     = 5,
    parameter int WORD_W = 8,
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          spi_cs_n
);

    localparam int MAX_HP = ((PRE_HI > PRE_LO) ? PRE_HI : PRE_LO) * (2 ** DIV_W);
    localparam int CNT_W  = $clog2(MAX_HP + 1);

    setup_t            setup_q;
    logic              start, tick;
    logic              eng_busy, eng_done, sck_q;
    logic [WORD_W-1:0] tx_q, eng_rx;
    logic [CNT_W-1:0]  pre_sel, div_plus, half_per;

    assign pre_sel  = setup_q.pre_hi ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO);
    assign div_plus = CNT_W'(setup_q.div) + CNT_W'(1);
    assign half_per = pre_sel * div_plus;

    assign spi_sck = eng_busy ? sck_q : setup_q.cpol;

    spi_host_regs #(.AW(AW), .WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .eng_busy (eng_busy),
        .eng_done (eng_done),
        .eng_rx   (eng_rx),
        .setup_q  (setup_q),
        .cs_n     (spi_cs_n),
        .start    (start),
        .tx_q     (tx_q)
    );

    spi_host_baud #(.CNT_W(CNT_W)) u_baud (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run      (eng_busy),
        .half_per (half_per),
        .tick     (tick)
    );

    spi_host_engine #(.WORD_W(WORD_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tick),
        .mode_in (mode_of(setup_q)),
        .tx_byte (bus_wdata[WORD_W-1:0]),
        .miso    (spi_miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sck_q   (sck_q),
        .mosi    (spi_mosi)
    );

endmodule

// File: rtl/spi_host_checks.sv
module spi_host_checks
    import spi_host_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [31:0]   wdata,
    input logic          cs_n,
    input logic          sck,
    input logic          busy,
    input logic          done,
    input logic          cpol_cfg,
    input logic          rx_full
);

    assert_cs_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(OFS_LINE)) |=> (cs_n == $past(wdata[LINE_SEL])));

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(OFS_TX) && !busy) |=> busy);

    assert_full_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(done));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(OFS_RX) && !done) |=> !rx_full);

    assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sck) |-> ($past(busy) || !$stable(cpol_cfg)));

endmodule

bind spi_host_ctrl spi_host_checks #(.AW(AW)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cs_n     (spi_cs_n),
    .sck      (spi_sck),
    .busy     (eng_busy),
    .done     (eng_done),
    .cpol_cfg (setup_q.cpol),
    .rx_full  (u_regs.rx_full)
);

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_host_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // slave model and timing monitor
    int   cyc = 0;
    int   last_tog, toggles, s_lead, s_trail, exp_hp;
    bit   bad_int, track, cur_cpol, cur_cpha;
    logic [7:0] s_tx, s_got;

    always @(negedge clk) cyc++;

    always @(spi_sck) begin
        if (track) begin
            if (toggles > 0 && (cyc - last_tog) != exp_hp) bad_int = 1;
            last_tog = cyc;
            toggles++;
            if (spi_sck != cur_cpol) begin
                if (!cur_cpha) s_got = {s_got[6:0], spi_mosi};
                else if (s_lead < 8) spi_miso = s_tx[7 - s_lead];
                s_lead++;
            end else begin
                if (!cur_cpha) begin
                    if (s_trail < 7) spi_miso = s_tx[6 - s_trail];
                end else begin
                    s_got = {s_got[6:0], spi_mosi};
                end
                s_trail++;
            end
        end
    end

    function automatic int half_period(input logic [7:0] cfg);
        return (cfg[5] ? 128 : 16) * (int'(cfg[4:0]) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // one byte exchange; poke: 1 = tx write mid-flight, 2 = setup write mid-flight
    task automatic xfer(input logic [7:0] cfg, input logic [7:0] mb, input logic [7:0] sb,
                        input int poke, input bit clear_by_flags);
        logic [31:0] r;
        bus_write(5'h00, {24'h0, cfg});
        cur_cpol = cfg[6]; cur_cpha = cfg[7]; exp_hp = half_period(cfg);
        s_tx = sb; s_got = '0; s_lead = 0; s_trail = 0; toggles = 0; bad_int = 0;
        spi_miso = cfg[7] ? 1'b0 : sb[7];
        track = 1;
        bus_write(5'h0C, {24'h0, mb});
        bus_read(5'h04, r);
        check(r[0] == 1'b1, "R7 busy after start", int'(r[0]), 1);
        if (poke != 0) begin
            repeat (20) @(negedge clk);
            if (poke == 1) bus_write(5'h0C, {24'h0, ~mb});
            else           bus_write(5'h00, {24'h0, cfg ^ 8'h01});
        end
        for (int i = 0; i < 40000; i++) begin
            bus_read(5'h04, r);
            if (r[2]) break;
        end
        track = 0;
        check(r[2] == 1'b1, "R8 full set at end", int'(r[2]), 1);
        check(r[0] == 1'b0, "R7 busy clear at end", int'(r[0]), 0);
        check(toggles == 16 && !bad_int, "R3 edge count and spacing", toggles, 16);
        check(spi_sck == cfg[6], "R4 idle level", int'(spi_sck), int'(cfg[6]));
        check(s_got == mb, "R5 mosi byte", int'(s_got), int'(mb));
        if (poke == 1) begin
            bus_read(5'h0C, r);
            check(r[7:0] == mb, "R9 tx ignored while busy", int'(r[7:0]), int'(mb));
        end
        if (poke == 2) begin
            check(!bad_int, "R10 timing unchanged mid-flight", int'(bad_int), 0);
            bus_read(5'h00, r);
            check(r[7:0] == (cfg ^ 8'h01), "R10 setup readback", int'(r[7:0]), int'(cfg ^ 8'h01));
        end
        if (clear_by_flags) begin
            bus_write(5'h04, 32'h0);
            bus_read(5'h04, r);
            check(r[2] == 1'b0, "R8 cleared by flags write", int'(r[2]), 0);
        end
        bus_read(5'h10, r);
        check(r[7:0] == sb, "R6 received byte", int'(r[7:0]), int'(sb));
        bus_read(5'h04, r);
        check(r[2] == 1'b0, "R8 cleared after rx read", int'(r[2]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5eed_1234));
        track = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        check(spi_cs_n == 1'b1, "R1 cs after reset", int'(spi_cs_n), 1);
        check(spi_sck == 1'b0, "R1 sck after reset", int'(spi_sck), 0);
        bus_read(5'h04, r);
        check(r == 32'h0, "R1 flags after reset", r, 0);
        bus_read(5'h00, r);
        check(r == 32'h0, "R1 setup after reset", r, 0);
        bus_read(5'h08, r);
        check(r == 32'h40, "R1 line after reset", r, 32'h40);

        bus_write(5'h08, 32'h21);
        #1 check(spi_cs_n == 1'b0, "R2 select asserted", int'(spi_cs_n), 0);

        // directed: each mode, fastest setting
        xfer(8'h00, 8'hA5, 8'h3C, 0, 0);
        xfer(8'h40, 8'h81, 8'h7E, 0, 0);
        xfer(8'h80, 8'h5A, 8'hC3, 0, 0);
        xfer(8'hC0, 8'hFF, 8'h00, 0, 0);
        // divider corners
        xfer(8'h20, 8'h12, 8'h34, 0, 0);
        xfer(8'h1F, 8'hE7, 8'h18, 0, 0);
        // mid-flight writes and flag clearing
        xfer(8'h41, 8'h96, 8'h69, 1, 0);
        xfer(8'h82, 8'h0F, 8'hF0, 2, 0);
        xfer(8'h83, 8'hC6, 8'h5B, 0, 1);

        for (int k = 0; k < 16; k++) begin
            logic [7:0] cfg;
            cfg = {2'($urandom), 1'b0, 3'b000, 2'($urandom)};
            xfer(cfg, 8'($urandom), 8'($urandom), 0, 0);
        end

        bus_write(5'h08, 32'h61);
        #1 check(spi_cs_n == 1'b1, "R2 select released", int'(spi_cs_n), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule